// File: doc/BRIEF.md
# Bus Cycle Tracker with Wait Timer

This block follows processor bus cycles and tells neighbouring command logic whether a cycle is open. It runs on the double-frequency processor clock. It watches the active-low address strobe and ready inputs directly, with no resampling stage. An internal phase toggle picks every second clock edge, and only those edges evaluate the strobes. Each such edge lines up with the end of a processor-clock period. The tracker treats bus cycles as strictly non-overlapping. A new address strobe is therefore ignored until ready closes the open cycle.

The second half of the block is a wait timer. The command logic pulses `start` when it opens a peripheral access and supplies the number of extra wait steps on `wait_count`. The timer counts in whole double-frequency clock periods and then drives `timedly_n` low as a handshake. The handshake stays low until the tracker sees ready close the bus cycle. Choosing the count for each device is left to the caller.

Top module: `bus_cycle_timer`

## Requirements
- R1: While reset is held and directly after it, `buscyc_n` and `timedly_n` are both high, the phase toggle is cleared and the timer is idle.
- R2: Only every second rising edge evaluates `ads_n` and `ready_n`, starting with the second rising edge after reset release. A strobe present only at the other edges has no effect on `buscyc_n` or `timedly_n`.
- R3: With no cycle open, `ads_n` low at an evaluating edge drives `buscyc_n` low right after that edge.
- R4: With a cycle open, `ready_n` low at an evaluating edge drives `buscyc_n` high right after that edge. `ads_n` low at an evaluating edge while a cycle is open is ignored.
- R5: `start` high at a rising edge while the timer is idle loads `wait_count` = N. `timedly_n` is high after that edge and after the next N edges, and it goes low right after edge N+1 counted from the loading edge.
- R6: A count of zero drives `timedly_n` low right after the first edge that follows the loading edge.
- R7: Once low, `timedly_n` stays low until `ready_n` is seen low at an evaluating edge while a cycle is open, and it is high right after that edge. Ready seen while no cycle is open leaves it low.
- R8: `start` is ignored while the timer is counting or while `timedly_n` is held low. Neither the expiry time nor the release is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-frequency processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ads_n | input | 1 | Address strobe, active low, evaluated directly |
| ready_n | input | 1 | Cycle-end ready, active low, evaluated directly |
| start | input | 1 | One-clock pulse from the command logic that opens a timed access |
| wait_count | input | CW (6) | Wait steps in double-frequency clock periods |
| buscyc_n | output | 1 | Low while a bus cycle is open |
| timedly_n | output | 1 | Low once the programmed delay has elapsed, until the cycle ends |

## Verification
The bench places strobes on the non-evaluating edges. A design that sampled on every edge, or on the wrong phase, would open or close cycles there. Delays of zero, one, a middle value and the largest count are each checked edge by edge. This catches an off-by-one in the reload or a zero count treated as a full wrap. A second `start` is sent both in the middle of a count and during the hold, and ready is given while no cycle is open. A design that reloads, or that releases on any ready, would then show a late, early or missing `timedly_n`.

// File: rtl/bct_pkg.sv
package bct_pkg;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_BUSY = 1'b1
  } trk_state_t;

  // Counter has reached its terminal value.
  function automatic logic cnt_at_end(input logic [31:0] v);
    return (v == 32'd0);
  endfunction

  // Number of edges from the loading edge until the handshake drops.
  function automatic int unsigned edges_to_flag(input int unsigned n);
    return n + 1;
  endfunction

endpackage

// File: rtl/bct_phase.sv
module bct_phase (
  input  logic clk,
  input  logic rst_n,
  output logic sample_en
);

  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  // Phase 1 marks the edge that closes a processor-clock period.
  assign sample_en = ph_q;

endmodule

// File: rtl/bct_tracker.sv
module bct_tracker
  import bct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic ads_n,
  input  logic ready_n,
  output logic busy,
  output logic rdy_seen
);

  trk_state_t st_q, st_d;
  logic       ads_seen;

  assign ads_seen = sample_en & ~ads_n;
  assign rdy_seen = sample_en & ~ready_n & (st_q == TRK_BUSY);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TRK_IDLE: if (ads_seen) st_d = TRK_BUSY;
      TRK_BUSY: if (rdy_seen) st_d = TRK_IDLE;
      default:  st_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TRK_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q == TRK_BUSY);

endmodule

// File: rtl/bct_timer.sv
module bct_timer
  import bct_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] wait_count,
  input  logic          release_i,
  output logic          held,
  output logic          load,
  output logic          expire
);

  logic          running_q;
  logic [CW-1:0] cnt_q;
  logic          held_q;

  assign load   = start & ~running_q & ~held_q;
  assign expire = running_q & cnt_at_end(32'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (load) begin
      running_q <= 1'b1;
      cnt_q     <= wait_count;
    end else if (expire) begin
      running_q <= 1'b0;
    end else if (running_q) begin
      cnt_q     <= cnt_q - 1'b1;
    end
  end

  // Expiry takes priority over a release at the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held_q <= 1'b0;
    else if (expire)    held_q <= 1'b1;
    else if (release_i) held_q <= 1'b0;
  end

  assign held = held_q;

endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
  parameter int CW = 6
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          ads_n,
  input  logic          ready_n,
  input  logic          start,
  input  logic [CW-1:0] wait_count,
  output logic          buscyc_n,
  output logic          timedly_n
);

  logic sample_en;
  logic busy;
  logic rdy_seen;
  logic held;
  logic tmr_load;
  logic tmr_expire;

  bct_phase u_phase (
    .clk       (clk2x),
    .rst_n     (rst_n),
    .sample_en (sample_en)
  );

  bct_tracker u_trk (
    .clk       (clk2x),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .ads_n     (ads_n),
    .ready_n   (ready_n),
    .busy      (busy),
    .rdy_seen  (rdy_seen)
  );

  bct_timer #(.CW(CW)) u_tmr (
    .clk        (clk2x),
    .rst_n      (rst_n),
    .start      (start),
    .wait_count (wait_count),
    .release_i  (rdy_seen),
    .held       (held),
    .load       (tmr_load),
    .expire     (tmr_expire)
  );

  assign buscyc_n  = ~busy;
  assign timedly_n = ~held;

endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ads_n,
  input logic          ready_n,
  input logic [CW-1:0] wait_count,
  input logic          buscyc_n,
  input logic          timedly_n,
  input logic          sample_en,
  input logic          rdy_seen,
  input logic          tmr_load,
  input logic          tmr_expire
);

  p_phase_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> !sample_en);
  p_phase_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> sample_en);
  p_quiet_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(buscyc_n));
  p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && !ads_n && buscyc_n |=> !buscyc_n);
  p_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && !ready_n && !buscyc_n |=> buscyc_n);
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && ready_n && !buscyc_n |=> !buscyc_n);
  p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_load && (wait_count == '0) |=> timedly_n ##1 !timedly_n);
  p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !timedly_n && !rdy_seen |=> !timedly_n);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !timedly_n && rdy_seen && !tmr_expire |=> timedly_n);
  p_no_load_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !timedly_n |-> !tmr_load);

  // Delay window measured with a counter instead of a long $past.
  logic          win_on;
  logic [CW+1:0] elapsed;
  logic [CW+1:0] saved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_on  <= 1'b0;
      elapsed <= '0;
      saved   <= '0;
    end else begin
      if (tmr_load) begin
        win_on  <= 1'b1;
        elapsed <= (CW+2)'(1);
        saved   <= (CW+2)'(wait_count);
      end else if (win_on) begin
        elapsed <= elapsed + 1'b1;
        if (!timedly_n) win_on <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      p_no_reload_r8: assert (!(win_on && timedly_n && tmr_load));
      p_not_early_r5: assert (!(win_on && timedly_n && elapsed > saved + 1'b1));
      p_on_time_r5:   assert (!(win_on && !timedly_n && elapsed != saved + 2'd2));
    end
  end

endmodule

bind bus_cycle_timer bct_checker #(.CW(CW)) u_chk (
  .clk        (clk2x),
  .rst_n      (rst_n),
  .ads_n      (ads_n),
  .ready_n    (ready_n),
  .wait_count (wait_count),
  .buscyc_n   (buscyc_n),
  .timedly_n  (timedly_n),
  .sample_en  (sample_en),
  .rdy_seen   (rdy_seen),
  .tmr_load   (tmr_load),
  .tmr_expire (tmr_expire)
);

// File: tb/bus_cycle_timer_bench.sv
`timescale 1ns/1ps
module bus_cycle_timer_bench;

  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ads_n = 1'b1;
  logic          ready_n = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] wait_count = '0;
  logic          buscyc_n;
  logic          timedly_n;

  int  n_chk = 0;
  int  n_bad = 0;
  int  e = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) e <= e + 1;

  bus_cycle_timer #(.CW(CW)) u_bus_cycle_timer (
    .clk2x(clk), .rst_n(rst_n), .ads_n(ads_n), .ready_n(ready_n),
    .start(start), .wait_count(wait_count),
    .buscyc_n(buscyc_n), .timedly_n(timedly_n)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  // Next rising edge evaluates strobes when e is odd at a falling edge.
  task automatic to_sample();    if (e % 2 == 0) tick(); endtask
  task automatic to_nonsample(); if (e % 2 == 1) tick(); endtask

  task automatic bus_begin();
    to_sample(); ads_n = 1'b0; tick(); ads_n = 1'b1;
  endtask
  task automatic bus_end();
    to_sample(); ready_n = 1'b0; tick(); ready_n = 1'b1;
  endtask

  task automatic t_reset();
    chk(buscyc_n, 1'b1, "R1 buscyc_n in reset");
    chk(timedly_n, 1'b1, "R1 timedly_n in reset");
    @(negedge clk); rst_n = 1'b1;
    tick(); tick();
    chk(buscyc_n, 1'b1, "R1 buscyc_n after reset");
    chk(timedly_n, 1'b1, "R1 timedly_n after reset");
  endtask

  task automatic t_phase();
    to_nonsample(); ads_n = 1'b0; tick(); ads_n = 1'b1;
    chk(buscyc_n, 1'b1, "R2 ads on off-phase edge");
    tick();
    chk(buscyc_n, 1'b1, "R2 still idle");
  endtask

  task automatic t_cycle();
    bus_begin();
    chk(buscyc_n, 1'b0, "R3 cycle opened");
    tick();
    chk(buscyc_n, 1'b0, "R3 cycle stays open");
    to_nonsample(); ready_n = 1'b0; tick(); ready_n = 1'b1;
    chk(buscyc_n, 1'b0, "R2 ready on off-phase edge");
    bus_begin();
    chk(buscyc_n, 1'b0, "R4 ads while open ignored");
    bus_end();
    chk(buscyc_n, 1'b1, "R4 cycle closed");
  endtask

  task automatic t_delay(input int n, input string tag);
    bus_begin();
    start = 1'b1; wait_count = CW'(n); tick(); start = 1'b0;
    chk(timedly_n, 1'b1, {tag, " high after load edge"});
    for (int j = 1; j <= n; j++) begin
      tick();
      chk(timedly_n, 1'b1, {tag, " high while counting"});
    end
    tick();
    chk(timedly_n, 1'b0, {tag, " low at expiry"});
    for (int j = 0; j < 3; j++) tick();
    chk(timedly_n, 1'b0, "R7 held low");
    bus_end();
    chk(timedly_n, 1'b1, "R7 released by ready");
    chk(buscyc_n, 1'b1, "R4 closed with release");
  endtask

  task automatic t_ready_idle();
    start = 1'b1; wait_count = CW'(2); tick(); start = 1'b0;
    for (int j = 0; j < 3; j++) tick();
    chk(timedly_n, 1'b0, "R5 expired without cycle");
    bus_end();
    chk(timedly_n, 1'b0, "R7 ready with no cycle ignored");
    bus_begin(); bus_end();
    chk(timedly_n, 1'b1, "R7 released in cycle");
  endtask

  task automatic t_ignore();
    bus_begin();
    start = 1'b1; wait_count = CW'(5); tick(); start = 1'b0;
    for (int j = 1; j <= 6; j++) begin
      if (j == 2) begin start = 1'b1; wait_count = '0; end
      tick(); start = 1'b0;
      chk(timedly_n, (j == 6) ? 1'b0 : 1'b1, "R8 start while counting");
    end
    start = 1'b1; wait_count = '0; tick(); start = 1'b0;
    chk(timedly_n, 1'b0, "R8 start while held");
    bus_end();
    chk(timedly_n, 1'b1, "R8 release after held start");
    for (int j = 0; j < 3; j++) tick();
    chk(timedly_n, 1'b1, "R8 no late reload");
  endtask

  initial begin
    t_reset();
    t_phase();
    t_cycle();
    t_delay(3, "R5 n=3");
    t_delay(0, "R6 n=0");
    t_delay(1, "R5 n=1");
    t_delay(63, "R5 n=max");
    t_ready_idle();
    t_ignore();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule